// File: doc/BRIEF.md
# Pseudo-random ALU self-test harness

The block checks a small 4-bit arithmetic/logic unit against itself. A 12-bit linear feedback shift register steps through a pseudo-random sequence, and the bits of its state drive two copies of the ALU: a reference copy and a copy in which a stuck-at-zero defect on the AND operation can be switched on. The complete 8-bit results of the two copies are XORed bit by bit. Any 1 bit in that XOR means the copies disagree.

A registered per-cycle mismatch flag reports each disagreement. A sticky error flag records the first one. A step counter gives the number of register advances that came before the stimulus which first exposed the defect. The live stimulus and both ALU results are brought out so that the sequence can be watched.

Top module: `alu_selftest_top`

## Requirements
- R1: A synchronous reset loads the register with the seed 12'hACE. On each clock with `run_en` high the state shifts left by one, and the new bit 0 is the XOR of state bits 11, 5, 3 and 0 (polynomial x^12+x^6+x^4+x+1). The state is never zero and first returns to the seed after 4095 advances.
- R2: While `run_en` is low the state, and with it the stimulus, holds its value.
- R3: The stimulus fields are taken from the state as follows: `stim_a` = state[3:0], `stim_b` = state[7:4], `stim_cin` = state[8], `stim_op` = state[11:9].
- R4: The opcodes are 0 AND, 1 OR, 2 XOR, 3 A+1, 4 A-1, 5 A+B+cin, 6 A>B, 7 A<B. Each is computed on 8 bits with the operands zero-extended. Bits 6:0 appear on the result port and bit 7 on the carry port. A compare gives 1 or 0.
- R5: Decrementing A=0 wraps to 8'hFF, so the result is 7'h7F with carry 1. The logic and compare operations always give carry 0.
- R6: With `inject_en` high and opcode 0, the defective copy outputs result 0 and carry 0. With any other opcode, or with `inject_en` low, it matches the reference copy.
- R7: `mismatch` is high in the cycle after a clock edge at which the two 8-bit results differed, and low otherwise.
- R8: `error_seen` rises together with the first `mismatch` and stays high until reset, whatever `inject_en` does afterwards.
- R9: `first_err_step` holds the number of advances taken since reset before the stimulus that gave the first mismatch, and stays frozen from then on. The step count saturates at its maximum.
- R10: With `inject_en` low, no mismatch occurs over a full period of the sequence.
- R11: Reset clears `mismatch`, `error_seen` and `first_err_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Advance the stimulus register |
| inject_en | input | 1 | Enable the stuck-at-zero AND defect |
| stim_a | output | 4 | Operand A in use |
| stim_b | output | 4 | Operand B in use |
| stim_cin | output | 1 | Carry-in in use |
| stim_op | output | 3 | Opcode in use |
| gold_res | output | 7 | Reference ALU result bits 6:0 |
| gold_cout | output | 1 | Reference ALU bit 7 |
| dut_res | output | 7 | Defective ALU result bits 6:0 |
| dut_cout | output | 1 | Defective ALU bit 7 |
| mismatch | output | 1 | Registered per-cycle disagreement |
| error_seen | output | 1 | Sticky error flag |
| first_err_step | output | 16 | Step count at the first disagreement |

## Verification
The assertions run on every cycle and cover these properties: the state is never zero, it holds while idle and shifts correctly while running, the two copies agree whenever the defect is off or the opcode is not AND, the error flag is sticky and implied by `mismatch`, and the captured step count stays frozen once set.

Other properties can only be shown by the bench's scenarios, which compare everything against a behavioural model on every clock:
- the 4095-state period;
- the one-cycle latency of `mismatch` and the exact step value captured;
- the arithmetic results of each opcode, including the decrement wrap;
- the flag surviving after the defect is switched off;
- the clean run of a full period with the defect off.

// File: rtl/alu_st_pkg.sv
package alu_st_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_ADC = 3'd5,
    OP_GT  = 3'd6,
    OP_LT  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/lfsr_stim.sv
module lfsr_stim #(
  parameter int          LW   = 12,
  parameter logic [LW-1:0] SEED = 12'hACE,
  parameter logic [LW-1:0] TAPS = 12'h829
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  output logic [LW-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)         state <= SEED;
    else if (run_en) state <= {state[LW-2:0], fb};
  end

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(state)); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    run_en |=> state[LW-1:1] == $past(state[LW-2:0])); // R1
endmodule

// File: rtl/alu4.sv
module alu4
  import alu_st_pkg::*;
#(
  parameter int DW        = 4,
  parameter bit HAS_FAULT = 1'b0,
  localparam int RW       = 2 * DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic [2:0]    op,
  input  logic          inject,
  output logic [RW-2:0] res,
  output logic          cout
);
  logic [RW-1:0] ax, bx, full, outv;

  assign ax = RW'(a);
  assign bx = RW'(b);

  always_comb begin
    case (alu_op_e'(op))
      OP_AND:  full = ax & bx;
      OP_OR:   full = ax | bx;
      OP_XOR:  full = ax ^ bx;
      OP_INC:  full = ax + RW'(1);
      OP_DEC:  full = ax - RW'(1);
      OP_ADC:  full = ax + bx + RW'(cin);
      OP_GT:   full = RW'(a > b);
      default: full = RW'(a < b);
    endcase
  end

  generate
    if (HAS_FAULT) begin : g_faulty
      always_comb begin
        if (inject && alu_op_e'(op) == OP_AND) outv = '0;
        else                                   outv = full;
      end
    end else begin : g_clean
      logic unused_inject;
      assign unused_inject = inject;
      assign outv = full;
    end
  endgenerate

  assign res  = outv[RW-2:0];
  assign cout = outv[RW-1];
endmodule

// File: rtl/mismatch_detect.sv
module mismatch_detect #(
  parameter int RW     = 8,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [RW-1:0]     gold_full,
  input  logic [RW-1:0]     dut_full,
  output logic              mismatch,
  output logic              error_seen,
  output logic [STEP_W-1:0] first_err_step
);
  localparam logic [STEP_W-1:0] STEP_MAX = '1;

  logic [RW-1:0]     diff;
  logic              differ;
  logic [STEP_W-1:0] step_cnt;

  assign diff   = gold_full ^ dut_full;
  assign differ = |diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch       <= 1'b0;
      error_seen     <= 1'b0;
      first_err_step <= '0;
      step_cnt       <= '0;
    end else begin
      mismatch <= differ;
      if (differ && !error_seen) begin
        error_seen     <= 1'b1;
        first_err_step <= step_cnt;
      end
      if (run_en && step_cnt != STEP_MAX) step_cnt <= step_cnt + 1'b1;
    end
  end

  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (rst)
    error_seen |=> error_seen); // R8
  AST_MISMATCH_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    mismatch |-> error_seen); // R8
  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    error_seen |=> $stable(first_err_step)); // R9
endmodule

// File: rtl/alu_selftest_top.sv
module alu_selftest_top #(
  parameter int          DW     = 4,
  parameter int          STEP_W = 16,
  parameter logic [11:0] SEED   = 12'hACE,
  localparam int         LW     = 2 * DW + 4,
  localparam int         RW     = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              inject_en,
  output logic [DW-1:0]     stim_a,
  output logic [DW-1:0]     stim_b,
  output logic              stim_cin,
  output logic [2:0]        stim_op,
  output logic [RW-2:0]     gold_res,
  output logic              gold_cout,
  output logic [RW-2:0]     dut_res,
  output logic              dut_cout,
  output logic              mismatch,
  output logic              error_seen,
  output logic [STEP_W-1:0] first_err_step
);
  logic [LW-1:0] state;

  lfsr_stim #(.LW(LW), .SEED(SEED), .TAPS(12'h829)) i_lfsr (
    .clk(clk), .rst(rst), .run_en(run_en), .state(state)
  );

  assign stim_a   = state[DW-1:0];
  assign stim_b   = state[2*DW-1:DW];
  assign stim_cin = state[2*DW];
  assign stim_op  = state[2*DW+3:2*DW+1];

  alu4 #(.DW(DW), .HAS_FAULT(1'b0)) i_gold (
    .a(stim_a), .b(stim_b), .cin(stim_cin), .op(stim_op),
    .inject(1'b0), .res(gold_res), .cout(gold_cout)
  );

  alu4 #(.DW(DW), .HAS_FAULT(1'b1)) i_dut (
    .a(stim_a), .b(stim_b), .cin(stim_cin), .op(stim_op),
    .inject(inject_en), .res(dut_res), .cout(dut_cout)
  );

  mismatch_detect #(.RW(RW), .STEP_W(STEP_W)) i_det (
    .clk(clk), .rst(rst), .run_en(run_en),
    .gold_full({gold_cout, gold_res}), .dut_full({dut_cout, dut_res}),
    .mismatch(mismatch), .error_seen(error_seen),
    .first_err_step(first_err_step)
  );

  AST_CLEAN_AGREE: assert property (@(posedge clk) disable iff (rst)
    !inject_en |-> {gold_cout, gold_res} == {dut_cout, dut_res}); // R6
  AST_NONAND_AGREE: assert property (@(posedge clk) disable iff (rst)
    stim_op != 3'd0 |-> {gold_cout, gold_res} == {dut_cout, dut_res}); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !inject_en && !$past(inject_en) && !$past(rst) |=> !mismatch); // R10
endmodule

// File: tb/test_alu_selftest_top.sv
`timescale 1ns/1ps
module test_alu_selftest_top;
  localparam int SEED = 12'hACE;

  logic clk = 1'b0;
  logic rst = 1'b1, run_en = 1'b0, inject_en = 1'b0;
  logic [3:0] stim_a, stim_b;
  logic stim_cin;
  logic [2:0] stim_op;
  logic [6:0] gold_res, dut_res;
  logic gold_cout, dut_cout, mismatch, error_seen;
  logic [15:0] first_err_step;

  always #10 clk = ~clk;

  alu_selftest_top i_alu_selftest_top (
    .clk(clk), .rst(rst), .run_en(run_en), .inject_en(inject_en),
    .stim_a(stim_a), .stim_b(stim_b), .stim_cin(stim_cin), .stim_op(stim_op),
    .gold_res(gold_res), .gold_cout(gold_cout), .dut_res(dut_res),
    .dut_cout(dut_cout), .mismatch(mismatch), .error_seen(error_seen),
    .first_err_step(first_err_step)
  );

  int n_chk = 0, n_fail = 0;
  int m_state = SEED, m_step = 0, m_first = 0, period = 0;
  bit m_mis = 0, m_err = 0, done = 0, seen_borrow = 0;
  bit [7:0] seen_op = '0;

  function automatic int alu_ref(int s, bit faulty, bit inj);
    int a = s & 15, b = (s >> 4) & 15, c = (s >> 8) & 1, op = (s >> 9) & 7;
    int r;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: r = a + 1;
      4: r = (a - 1) & 255;
      5: r = a + b + c;
      6: r = (a > b) ? 1 : 0;
      default: r = (a < b) ? 1 : 0;
    endcase
    if (faulty && inj && op == 0) r = 0;
    return r;
  endfunction

  function automatic int lfsr_next(int s);
    int fb = ((s >> 11) ^ (s >> 5) ^ (s >> 3) ^ s) & 1;
    return ((s << 1) & 12'hFFF) | fb;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int g = alu_ref(m_state, 0, inject_en);
    int d = alu_ref(m_state, 1, inject_en);
    chk("R3 stim_a", stim_a, m_state & 15);
    chk("R3 stim_b", stim_b, (m_state >> 4) & 15);
    chk("R3 stim_cin", stim_cin, (m_state >> 8) & 1);
    chk("R1/R3 stim_op", stim_op, (m_state >> 9) & 7);
    chk("R4/R5 gold", {gold_cout, gold_res}, g);
    chk("R6 dut", {dut_cout, dut_res}, d);
    chk("R7 mismatch", mismatch, m_mis);
    chk("R8 error_seen", error_seen, m_err);
    chk("R9 first_err_step", first_err_step, m_first);
    seen_op[(m_state >> 9) & 7] = 1'b1;
    if (((m_state >> 9) & 7) == 4 && (m_state & 15) == 0) begin
      seen_borrow = 1'b1;
      chk("R5 decrement wrap", {gold_cout, gold_res}, 8'hFF);
    end
  endtask

  task automatic cycle(bit rs, bit run, bit inj);
    rst = rs; run_en = run; inject_en = inj;
    @(posedge clk);
    if (rs) begin
      m_state = SEED; m_step = 0; m_mis = 0; m_err = 0; m_first = 0;
    end else begin
      m_mis = alu_ref(m_state, 0, inj) != alu_ref(m_state, 1, inj);
      if (m_mis && !m_err) begin m_err = 1; m_first = m_step; end
      if (run) begin
        m_state = lfsr_next(m_state);
        if (m_step < 65535) m_step++;
        if (m_state == SEED && period == 0) period = m_step;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int held;
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1, 0, 0);
    // R11: reset state
    chk("R11 reset mismatch", mismatch, 0);
    chk("R11 reset error_seen", error_seen, 0);
    chk("R11 reset first_err_step", first_err_step, 0);
    chk("R1 seed", {stim_op, stim_cin, stim_b, stim_a}, SEED);
    // R10 + R1: full period, defect off
    for (int i = 0; i < 4100; i++) cycle(0, 1, 0);
    chk("R1 period", period, 4095);
    chk("R10 no error over period", error_seen, 0);
    // R2: idle hold
    held = {stim_op, stim_cin, stim_b, stim_a};
    for (int i = 0; i < 6; i++) cycle(0, 0, 1);
    chk("R2 hold while idle", {stim_op, stim_cin, stim_b, stim_a}, held);
    // R6 R7 R8 R9: defect on
    cycle(1, 0, 0);
    for (int i = 0; i < 300; i++) cycle(0, 1, 1);
    chk("R8 error raised", error_seen, 1);
    held = first_err_step;
    for (int i = 0; i < 60; i++) cycle(0, 1, 0);
    chk("R8 sticky after defect off", error_seen, 1);
    chk("R9 first step frozen", first_err_step, held);
    cycle(1, 1, 1);
    chk("R11 reset clears error", error_seen, 0);
    chk("R11 reset clears step", first_err_step, 0);
    // mixed pattern
    for (int i = 0; i < 800; i++) cycle(0, ($urandom % 4) != 0, $urandom % 2);
    for (int i = 0; i < 8; i++) chk("R4 opcode exercised", seen_op[i], 1);
    chk("R5 decrement borrow exercised", seen_borrow, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule